// File: doc/BRIEF.md
# Prioritized Nested Event Controller

This block arbitrates sixteen numbered event levels for a processor core. Level 0 has the highest priority and level 15 the lowest. Three status words describe the state of the block. The request word records every software raise that has not been serviced. The enable word decides which levels may be entered. The active word records the levels whose handlers are running, and it also holds a nesting-lock bit at position 4. The block picks the most urgent level that is requested and enabled. That level is entered only when it is more urgent than every handler already active and only when the nesting lock is clear. On entry the block issues a one-cycle entry pulse with the chosen level and a handler address equal to a programmable base plus four times the level number.

Software raises levels 5 to 15 one at a time. It changes the enable word with a direct write, with a disable pulse that clears the word, or with an enable pulse that loads a supplied value. Each handler releases the nesting lock once its return address is safe, which allows more urgent levels to preempt it. A return strobe retires the most urgent active handler. All three status words are visible on output ports at all times.

Top module: `prio_event_ctrl`

## Requirements
- R1: After reset the request, enable and active words are all zero and the entry pulse is low.
- R2: A raise of a level from 5 to 15 sets that level's request bit whether or not the level is enabled. A raise of a level from 0 to 4 changes nothing, so request bits 4..0 stay 0.
- R3: A request bit whose enable bit is 0 never causes an entry. The request stays set.
- R4: When several enabled levels are requested, only the lowest-numbered one is entered. The other request bits stay set.
- R5: A requested, enabled level is entered only if its number is strictly lower than every set active bit at positions 5 to 15. The active handlers below it keep their bits.
- R6: An entry is made one clock after the request, enable and active state that allows it becomes visible. In that cycle the entry pulse is high for one cycle, the chosen level and the handler address (base + 4 x level) appear, the level's request bit clears, and its active bit and active bit 4 (the nesting lock) are set.
- R7: While active bit 4 is set, no entry is made, even if levels are enabled during that time. The saved strobe clears bit 4, and a pending entry then follows one clock later.
- R8: A direct enable write loads the written value, an enable pulse loads its supplied value, and a disable pulse clears the enable word. If more than one is given in the same cycle, the direct write wins over the enable pulse, which wins over the disable pulse. The new enable word is used for arbitration from the next cycle on.
- R9: A return strobe clears the lowest-numbered set active bit among positions 5 to 15. No entry is made in the cycle of the strobe. Arbitration against the remaining active bits resumes in the next cycle.
- R10: If a raise of a level arrives in the same cycle in which that level is entered, the level's request bit remains set after the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raise_valid | input | 1 | Software raise strobe |
| raise_level | input | 4 | Level to raise |
| gdis_pulse | input | 1 | Global disable: clears the enable word |
| gen_pulse | input | 1 | Global enable: loads gen_mask |
| gen_mask | input | 16 | Enable value carried by the enable pulse |
| mask_wr | input | 1 | Direct enable-word write strobe |
| mask_wdata | input | 16 | Direct enable-word write value |
| ret_saved | input | 1 | Handler has saved its return address; clears the nesting lock |
| rti_pulse | input | 1 | Return from the most urgent active handler |
| vec_base | input | 32 | Base of the handler address table |
| take_pulse | output | 1 | One-cycle entry pulse |
| take_level | output | 4 | Level entered |
| take_vector | output | 32 | Handler address of the entered level |
| latch_word | output | 16 | Request word |
| mask_word | output | 16 | Enable word |
| pend_word | output | 16 | Active word, nesting lock at bit 4 |

## Verification
A raise, enable change, saved strobe or return strobe shows in the status words at the first clock edge after it is driven. The entry that this state allows appears at the next edge. The entry pulse, level and address therefore come two edges after the raise that completes the conditions, or one edge after an unmasking or lock release. The bench drives inputs and samples outputs on the falling edge, and it advances exactly that number of edges before each comparison. It also checks at each of those samples that no entry pulse appears when none is due. Request and active words are compared on bits 15 to 5 only, except where the nesting lock itself is under test.

// File: rtl/prio_event_pkg.sv
`timescale 1ns/1ps
// Shared constants of the prioritized event controller.
// Assumes levels below FIRST_USER are reserved and cannot be raised by software.
package prio_event_pkg;
    localparam int unsigned NUM_LVL    = 16;
    localparam int unsigned GLOBAL_BIT = 4;
    localparam int unsigned FIRST_USER = 5;
endpackage

// File: rtl/prio_first_set.sv
`timescale 1ns/1ps
// Finds the lowest-numbered set bit of a vector (the most urgent level).
// Assumes W >= 2; idx is zero when found is low.
module prio_first_set #(
    parameter int unsigned W  = 16,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set index is the one kept.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/prio_event_arb.sv
`timescale 1ns/1ps
// Arbitration: chooses the most urgent requested and enabled level, and
// allows entry only above all active handlers, with the lock clear and no return.
// Assumes latch/mask/pend are registered state; purely combinational.
module prio_event_arb #(
    parameter int unsigned NUM_LVL    = 16,
    parameter int unsigned GLOBAL_BIT = 4,
    parameter int unsigned FIRST_USER = 5,
    localparam int unsigned LVL_W     = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] latch,
    input  logic [NUM_LVL-1:0] mask,
    input  logic [NUM_LVL-1:0] pend,
    input  logic               rti_pulse,
    output logic               go,
    output logic [LVL_W-1:0]   go_lvl,
    output logic               top_found,
    output logic [LVL_W-1:0]   top_lvl
);
    localparam logic [NUM_LVL-1:0] USER_BITS = {NUM_LVL{1'b1}} << FIRST_USER;

    logic [NUM_LVL-1:0] cand;
    logic [NUM_LVL-1:0] active_user;
    logic               cand_found;

    // Qualify requests by enables and restrict both words to software levels.
    always_comb begin
        cand        = latch & mask & USER_BITS;
        active_user = pend & USER_BITS;
    end

    prio_first_set #(.W(NUM_LVL)) u_cand_enc (
        .vec   (cand),
        .found (cand_found),
        .idx   (go_lvl)
    );

    prio_first_set #(.W(NUM_LVL)) u_pend_enc (
        .vec   (active_user),
        .found (top_found),
        .idx   (top_lvl)
    );

    // Entry needs strict preemption, a clear nesting lock and no return this cycle.
    always_comb begin
        go = cand_found && !pend[GLOBAL_BIT] && !rti_pulse &&
             (!top_found || (go_lvl < top_lvl));
    end
endmodule

// File: rtl/prio_event_ctrl.sv
`timescale 1ns/1ps
// Prioritized nested event controller: holds the request, enable and active
// words, applies raises, enable updates, lock release and returns, and issues
// a registered entry pulse with level and handler address.
// Assumes one raise per cycle; levels below FIRST_USER are ignored.
module prio_event_ctrl #(
    parameter int unsigned NUM_LVL = prio_event_pkg::NUM_LVL,
    parameter int unsigned ADDR_W  = 32,
    localparam int unsigned LVL_W  = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               raise_valid,
    input  logic [LVL_W-1:0]   raise_level,
    input  logic               gdis_pulse,
    input  logic               gen_pulse,
    input  logic [NUM_LVL-1:0] gen_mask,
    input  logic               mask_wr,
    input  logic [NUM_LVL-1:0] mask_wdata,
    input  logic               ret_saved,
    input  logic               rti_pulse,
    input  logic [ADDR_W-1:0]  vec_base,
    output logic               take_pulse,
    output logic [LVL_W-1:0]   take_level,
    output logic [ADDR_W-1:0]  take_vector,
    output logic [NUM_LVL-1:0] latch_word,
    output logic [NUM_LVL-1:0] mask_word,
    output logic [NUM_LVL-1:0] pend_word
);
    localparam int unsigned GBIT = prio_event_pkg::GLOBAL_BIT;
    localparam int unsigned FUSR = prio_event_pkg::FIRST_USER;
    localparam logic [LVL_W-1:0] FIRST_LVL = LVL_W'(FUSR);

    logic [NUM_LVL-1:0] latch_q, latch_n;
    logic [NUM_LVL-1:0] mask_q, mask_n;
    logic [NUM_LVL-1:0] pend_q, pend_n;
    logic               go, top_found, raise_ok;
    logic [LVL_W-1:0]   go_lvl, top_lvl;

    prio_event_arb #(
        .NUM_LVL    (NUM_LVL),
        .GLOBAL_BIT (GBIT),
        .FIRST_USER (FUSR)
    ) u_arb (
        .latch     (latch_q),
        .mask      (mask_q),
        .pend      (pend_q),
        .rti_pulse (rti_pulse),
        .go        (go),
        .go_lvl    (go_lvl),
        .top_found (top_found),
        .top_lvl   (top_lvl)
    );

    // Next request word: entry clears, a raise sets (raise wins on the same level).
    always_comb begin
        raise_ok = raise_valid && (raise_level >= FIRST_LVL);
        latch_n  = latch_q;
        if (go)       latch_n[go_lvl]      = 1'b0;
        if (raise_ok) latch_n[raise_level] = 1'b1;
    end

    // Next active word: return retires the most urgent handler, entry sets level and lock.
    always_comb begin
        pend_n = pend_q;
        if (rti_pulse && top_found) pend_n[top_lvl] = 1'b0;
        if (ret_saved)              pend_n[GBIT]    = 1'b0;
        if (go) begin
            pend_n[go_lvl] = 1'b1;
            pend_n[GBIT]   = 1'b1;
        end
    end

    // Next enable word: direct write over enable pulse over disable pulse.
    always_comb begin
        mask_n = mask_q;
        if (mask_wr)         mask_n = mask_wdata;
        else if (gen_pulse)  mask_n = gen_mask;
        else if (gdis_pulse) mask_n = '0;
    end

    // State registers and registered entry outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q     <= '0;
            mask_q      <= '0;
            pend_q      <= '0;
            take_pulse  <= 1'b0;
            take_level  <= '0;
            take_vector <= '0;
        end else begin
            latch_q    <= latch_n;
            mask_q     <= mask_n;
            pend_q     <= pend_n;
            take_pulse <= go;
            if (go) begin
                take_level  <= go_lvl;
                take_vector <= vec_base + ADDR_W'({go_lvl, 2'b00});
            end
        end
    end

    assign latch_word = latch_q;
    assign mask_word  = mask_q;
    assign pend_word  = pend_q;
endmodule

// File: rtl/prio_event_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for prio_event_ctrl, attached by bind.
// Keeps its own one-cycle copies of the enable and active words.
module prio_event_ctrl_chk #(
    parameter int unsigned NUM_LVL = 16,
    parameter int unsigned ADDR_W  = 32,
    localparam int unsigned LVL_W  = $clog2(NUM_LVL)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rti_pulse,
    input logic               take_pulse,
    input logic [LVL_W-1:0]   take_level,
    input logic [NUM_LVL-1:0] latch_word,
    input logic [NUM_LVL-1:0] mask_word,
    input logic [NUM_LVL-1:0] pend_word
);
    localparam int unsigned GBIT = prio_event_pkg::GLOBAL_BIT;
    localparam int unsigned FUSR = prio_event_pkg::FIRST_USER;
    localparam logic [NUM_LVL-1:0] USER_BITS = {NUM_LVL{1'b1}} << FUSR;

    logic [NUM_LVL-1:0] mask_q, pend_q, upto;

    // Previous-cycle copies of the enable and active words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pend_q <= '0;
        end else begin
            mask_q <= mask_word;
            pend_q <= pend_word;
        end
    end

    // Bits at or above the urgency of the level just entered.
    always_comb begin
        for (int i = 0; i < NUM_LVL; i++) upto[i] = (i <= int'(take_level));
    end

    AST_LOW_REQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        latch_word[FUSR-1:0] == '0);                                          // R2
    AST_ENTRY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> mask_q[take_level]);                                   // R3
    AST_ENTRY_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> ((pend_q & USER_BITS & upto) == '0));                  // R5
    AST_ENTRY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> (pend_word[take_level] && pend_word[GBIT]));           // R6
    AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[GBIT] |-> !take_pulse);                                        // R7
    AST_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |=> !take_pulse);                                          // R7
    AST_RETURN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rti_pulse |=> !take_pulse);                                           // R9
endmodule

bind prio_event_ctrl prio_event_ctrl_chk #(
    .NUM_LVL (NUM_LVL),
    .ADDR_W  (ADDR_W)
) u_chk (.*);

// File: tb/prio_event_ctrl_test.sv
`timescale 1ns/1ps
module prio_event_ctrl_test;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam logic [15:0] HI   = 16'hFFE0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raise_valid = 1'b0;
    logic [3:0]  raise_level = '0;
    logic        gdis_pulse = 1'b0, gen_pulse = 1'b0, mask_wr = 1'b0;
    logic [15:0] gen_mask = '0, mask_wdata = '0;
    logic        ret_saved = 1'b0, rti_pulse = 1'b0;
    logic [31:0] vec_base = BASE;
    logic        take_pulse;
    logic [3:0]  take_level;
    logic [31:0] take_vector;
    logic [15:0] latch_word, mask_word, pend_word;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    prio_event_ctrl uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_raise(input int lvl);
        raise_valid = 1'b1; raise_level = 4'(lvl); cyc(1); raise_valid = 1'b0;
    endtask

    task automatic do_mask(input logic [15:0] m);
        mask_wr = 1'b1; mask_wdata = m; cyc(1); mask_wr = 1'b0;
    endtask

    task automatic do_saved();
        ret_saved = 1'b1; cyc(1); ret_saved = 1'b0;
    endtask

    task automatic do_rti();
        rti_pulse = 1'b1; cyc(1); rti_pulse = 1'b0;
    endtask

    task automatic chk_take(input string req, input int lvl);
        chk(req, {31'd0, take_pulse}, 32'd1);
        chk(req, {28'd0, take_level}, 32'(lvl));
        chk(req, take_vector, BASE + 32'(4 * lvl));
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 latch", {16'd0, latch_word}, 0);
        chk("R1 mask", {16'd0, mask_word}, 0);
        chk("R1 pend", {16'd0, pend_word}, 0);
        chk("R1 take", {31'd0, take_pulse}, 0);

        // Reserved levels are ignored
        do_mask(16'hFFFF);
        for (int l = 0; l < 5; l++) begin
            do_raise(l);
            chk("R2 low raise", {16'd0, latch_word}, 0);
            cyc(1);
            chk("R2 low take", {31'd0, take_pulse}, 0);
        end

        // Single-level sweep
        for (int l = 5; l < 16; l++) begin
            do_raise(l);
            chk("R2 latch", {16'd0, latch_word & HI}, 32'(1 << l));
            chk("R6 early", {31'd0, take_pulse}, 0);
            cyc(1);
            chk_take("R6 entry", l);
            chk("R6 pend", {16'd0, pend_word}, 32'((1 << l) | 16));
            chk("R6 latch clr", {16'd0, latch_word & HI}, 0);
            do_saved();
            chk("R7 unlock", {16'd0, pend_word}, 32'(1 << l));
            do_rti();
            chk("R9 retire", {16'd0, pend_word}, 0);
        end

        // All pairs: masked latching, priority, strictness, re-arbitration
        for (int a = 5; a < 15; a++) begin
            for (int b = a + 1; b < 16; b++) begin
                do_mask(16'h0000);
                do_raise(a);
                do_raise(b);
                cyc(1);
                chk("R3 held", {16'd0, latch_word & HI}, 32'((1 << a) | (1 << b)));
                chk("R3 no take", {31'd0, take_pulse}, 0);
                do_mask(16'hFFFF);
                cyc(1);
                chk_take("R4 winner", a);
                chk("R4 loser kept", {16'd0, latch_word & HI}, 32'(1 << b));
                do_saved();
                cyc(2);
                chk("R5 no preempt", {31'd0, take_pulse}, 0);
                chk("R5 pend", {16'd0, pend_word}, 32'(1 << a));
                do_rti();
                chk("R9 rti cycle", {31'd0, take_pulse}, 0);
                cyc(1);
                chk_take("R9 rearb", b);
                do_saved();
                do_rti();
                chk("R9 clean", {16'd0, pend_word}, 0);
            end
        end

        // Nesting: more urgent level preempts an active one
        do_raise(12);
        cyc(1);
        chk_take("R5 first", 12);
        do_saved();
        do_raise(9);
        cyc(1);
        chk_take("R5 nest", 9);
        chk("R5 nest pend", {16'd0, pend_word}, 32'((1 << 12) | (1 << 9) | 16));
        do_saved();
        do_rti();
        chk("R9 top first", {16'd0, pend_word}, 32'(1 << 12));
        do_rti();
        chk("R9 empty", {16'd0, pend_word}, 0);

        // Lock blocks entry, enable/disable pulses, precedence
        do_mask(16'h0000);
        do_raise(5); do_raise(6); do_raise(9); do_raise(12);
        do_mask(16'h1000);
        cyc(1);
        chk_take("R4 only enabled", 12);
        gen_pulse = 1'b1; gen_mask = 16'h1200; cyc(1); gen_pulse = 1'b0;
        chk("R8 gen", {16'd0, mask_word}, 32'h1200);
        for (int i = 0; i < 3; i++) begin
            cyc(1);
            chk("R7 locked", {31'd0, take_pulse}, 0);
        end
        chk("R7 latched", {16'd0, latch_word & HI}, 32'h0260);
        do_saved();
        chk("R7 release cycle", {31'd0, take_pulse}, 0);
        cyc(1);
        chk_take("R7 after release", 9);
        gdis_pulse = 1'b1; cyc(1); gdis_pulse = 1'b0;
        chk("R8 gdis", {16'd0, mask_word}, 0);
        do_saved();
        cyc(3);
        chk("R3 disabled", {31'd0, take_pulse}, 0);
        gen_pulse = 1'b1; gen_mask = 16'h0040; cyc(1); gen_pulse = 1'b0;
        cyc(1);
        chk_take("R8 gen entry", 6);
        do_saved();
        mask_wr = 1'b1; mask_wdata = 16'h0800; gen_pulse = 1'b1; gen_mask = 16'h0020;
        gdis_pulse = 1'b1;
        cyc(1);
        mask_wr = 1'b0; gen_pulse = 1'b0; gdis_pulse = 1'b0;
        chk("R8 precedence", {16'd0, mask_word}, 32'h0800);
        gen_pulse = 1'b1; gen_mask = 16'h0800; gdis_pulse = 1'b1; cyc(1);
        gen_pulse = 1'b0; gdis_pulse = 1'b0;
        chk("R8 gen over gdis", {16'd0, mask_word}, 32'h0800);
        do_rti();
        chk("R9 pop 6", {16'd0, pend_word}, 32'h1200);
        do_rti();
        do_rti();
        chk("R9 pop all", {16'd0, pend_word}, 0);
        do_mask(16'h0020);
        cyc(1);
        chk_take("R8 write entry", 5);
        do_saved();
        do_rti();

        // Raise and entry of the same level in one cycle
        do_mask(16'hFFFF);
        do_raise(7);
        do_raise(7);
        chk_take("R10 entry", 7);
        chk("R10 latch kept", {16'd0, latch_word & HI}, 32'(1 << 7));
        do_saved();
        cyc(1);
        chk("R5 equal level", {31'd0, take_pulse}, 0);
        do_rti();
        cyc(1);
        chk_take("R10 second", 7);
        do_saved();
        do_rti();
        chk("R10 clean", {16'd0, latch_word | pend_word}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule